// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

The block measures how fast one of several candidate clocks runs. Software picks a monitored source, a reference clock and a window length, then sets the enable bit. The meter opens a window on a reference clock edge, counts rising edges of the chosen source until the window has lasted the programmed number of reference cycles, and then holds the raw count together with a done flag. Software turns the count into a frequency: count × reference frequency / window length × prescale.

The monitored and reference clocks are treated as asynchronous inputs. Each one passes through a two-flop synchronizer and an edge detector into the register clock domain, and all counting happens in that domain. The held count is therefore stable whenever the bus reads it. For correct counts, every monitored clock must run below half the register clock rate. A full measurement follows this sequence: pulse soft reset, write the configuration with enable set, poll the done flag, read the count, then pulse soft reset again.

Top module: `fm_meter`

## Requirements
- R1: The control register sits at offset 0x10 and reads back what was written, masked to its fields: prescale code at bits 29:28, reference select at bit 24, source index at bits 22:16, enable at bit 15, soft reset at bit 14, and window value at bits 11:0. Any other address reads 0.
- R2: After reset, the control register and the result register (offset 0x14) both read 0.
- R3: A window lasts (window value + 1) periods of the reference clock. Reference select 0 picks the primary reference, nominally 26 MHz. Reference select 1 picks the alternate reference.
- R4: The result register holds, in bits CNT_W-1:0, the number of rising edges of the selected source seen during the window. A source index of NUM_SRC or above counts nothing and reports 0.
- R5: Prescale code d counts only every 2^d-th source edge, giving division by 1, 2, 4 or 8.
- R6: While soft reset is 1, the count, the done flag and the window timer are held cleared, and the enable bit has no effect. Soft reset takes priority over enable.
- R7: Result bit 31 sets when the window ends. From then until the next soft reset, both bit 31 and the count stay unchanged.
- R8: If the selected source is stopped, either low or high, the measurement still finishes and reports a count of 0.
- R9: The done flag rises no earlier than (window value + 1) reference periods after enable, and no later than (window value + 2) reference periods plus 8 register clock cycles after enable.
- R10: The count saturates at all ones and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| mon_clk | input | NUM_SRC | Candidate clocks available for monitoring |
| ref_clk_a | input | 1 | Primary reference clock |
| ref_clk_b | input | 1 | Alternate reference clock |

## Verification
The main function is tested with a sweep over every source, every prescale code, both references and two short window lengths. The sources include four evenly spaced periods, two longer periods, one source stuck low and one stuck high. Because the reference periods are whole multiples of every source period, each count has one exact expected value. This separates a window that is one reference cycle off, a wrong prescale, a misrouted source or reference, and a counter that wraps. Out-of-range source indexes, a 512-cycle window, and a soft reset in the middle of a run check the boundary and priority rules. The done latency is bounded on both sides for every run.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int WIN_W = 12;
    localparam int SEL_W = 7;
    localparam int DIV_W = 2;

    localparam logic [31:0] CTRL_MASK = 32'h317F_CFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } fm_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ref_sel;
        logic [SEL_W-1:0] src;
        logic             enable;
        logic             sreset;
        logic [WIN_W-1:0] window;
    } fm_ctrl_t;

    // Configuration captured when a measurement is armed
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ref_sel;
        logic [SEL_W-1:0] src;
        logic [WIN_W-1:0] window;
    } fm_run_t;

    function automatic fm_ctrl_t ctrl_view(input logic [31:0] w);
        fm_ctrl_t c;
        c.div    = w[29:28];
        c.ref_sel = w[24];
        c.src    = w[22:16];
        c.enable = w[15];
        c.sreset = w[14];
        c.window = w[11:0];
        return c;
    endfunction

    function automatic logic [2:0] div_mask(input logic [DIV_W-1:0] d);
        case (d)
            2'd0:    return 3'b000;
            2'd1:    return 3'b001;
            2'd2:    return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fm_window.sv
module fm_window
    import fm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sreset,
    input  logic             enable,
    input  logic             ref_edge,
    input  logic [WIN_W-1:0] window,
    output fm_state_e        state,
    output logic             arm,
    output logic             cnt_en
);
    logic [WIN_W-1:0] ticks;
    logic             last;

    assign arm  = (state == ST_IDLE) && enable && !sreset;
    assign last = (state == ST_RUN) && ref_edge && (ticks == window);

    // Counting covers the half-open span from the opening edge to the closing edge
    assign cnt_en = !sreset &&
                    (((state == ST_ARM) && ref_edge) ||
                     ((state == ST_RUN) && !last));

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            state <= ST_IDLE;
            ticks <= '0;
        end else begin
            case (state)
                ST_IDLE: if (enable) state <= ST_ARM;
                ST_ARM: begin
                    if (ref_edge) begin
                        state <= ST_RUN;
                        ticks <= '0;
                    end
                end
                ST_RUN: begin
                    if (last)          state <= ST_DONE;
                    else if (ref_edge) ticks <= ticks + 1'b1;
                end
                default: state <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/fm_counter.sv
module fm_counter
    import fm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             mon_edge,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [2:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre   <= '0;
            count <= '0;
        end else if (cnt_en && mon_edge) begin
            if (pre == div_mask(div)) begin
                pre <= '0;
                if (count != CNT_MAX) count <= count + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fm_meter.sv
module fm_meter
    import fm_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int CNT_W   = 24,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_SRC-1:0] mon_clk,
    input  logic              ref_clk_a,
    input  logic              ref_clk_b
);
    localparam int                SYN_W   = NUM_SRC + 2;
    localparam logic [ADDR_W-1:0] CTRL_AD = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] RES_AD  = ADDR_W'(8'h14);

    logic [31:0]      ctrl_word;
    fm_ctrl_t         ctrl_v;
    fm_run_t          run_cfg;
    logic [SYN_W-1:0] syn, syn_prev, edges;
    logic             mon_edge, ref_edge;
    fm_state_e        state;
    logic             arm, cnt_en, done;
    logic [CNT_W-1:0] count;
    logic [31:0]      result;

    // Control register
    always_ff @(posedge clk) begin
        if (rst)                              ctrl_word <= '0;
        else if (bus_wr && bus_addr == CTRL_AD) ctrl_word <= bus_wdata & CTRL_MASK;
    end
    assign ctrl_v = ctrl_view(ctrl_word);

    always_ff @(posedge clk) begin
        if (rst) run_cfg <= '0;
        else if (arm) begin
            run_cfg.div     <= ctrl_v.div;
            run_cfg.ref_sel <= ctrl_v.ref_sel;
            run_cfg.src     <= ctrl_v.src;
            run_cfg.window  <= ctrl_v.window;
        end
    end

    // Bring every external clock into the register domain and mark rising edges
    fm_sync #(.W(SYN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ref_clk_b, ref_clk_a, mon_clk}),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) syn_prev <= '0;
        else     syn_prev <= syn;
    end

    for (genvar g = 0; g < SYN_W; g++) begin : g_edge
        assign edges[g] = syn[g] & ~syn_prev[g];
    end

    always_comb begin
        mon_edge = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (run_cfg.src == SEL_W'(i)) mon_edge = edges[i];
        end
    end

    assign ref_edge = run_cfg.ref_sel ? edges[NUM_SRC+1] : edges[NUM_SRC];

    fm_window u_window (
        .clk      (clk),
        .rst      (rst),
        .sreset   (ctrl_v.sreset),
        .enable   (ctrl_v.enable),
        .ref_edge (ref_edge),
        .window   (run_cfg.window),
        .state    (state),
        .arm      (arm),
        .cnt_en   (cnt_en)
    );

    fm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctrl_v.sreset || arm),
        .cnt_en   (cnt_en),
        .mon_edge (mon_edge),
        .div      (run_cfg.div),
        .count    (count)
    );

    assign done = (state == ST_DONE);

    always_comb begin
        result              = '0;
        result[31]          = done;
        result[CNT_W-1:0]   = count;
    end

    always_comb begin
        if (bus_addr == CTRL_AD)     bus_rdata = ctrl_word;
        else if (bus_addr == RES_AD) bus_rdata = result;
        else                         bus_rdata = '0;
    end
endmodule

// File: rtl/fm_meter_chk.sv
module fm_meter_chk
    import fm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             sreset,
    input logic             enable,
    input fm_state_e        state,
    input logic             done,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r6_sreset_clears: assert property (@(posedge clk) disable iff (rst)
        sreset |=> (count == '0) && !done);

    a_r6_sreset_over_enable: assert property (@(posedge clk) disable iff (rst)
        (sreset && enable) |=> (state == ST_IDLE));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !sreset) |=> done);

    a_r7_count_held: assert property (@(posedge clk) disable iff (rst)
        (done && !sreset) |=> $stable(count));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && !enable && !sreset) |=> $stable(count));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        ((count == CNT_MAX) && (state != ST_IDLE) && !sreset) |=> (count == CNT_MAX));
endmodule

bind fm_meter fm_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sreset (ctrl_v.sreset),
    .enable (ctrl_v.enable),
    .state  (state),
    .done   (done),
    .count  (count)
);

// File: tb/fm_meter_bench.sv
`timescale 1ns/1ps
module fm_meter_bench;
    localparam int NUM_SRC = 8;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int PR_A    = 96;
    localparam int PR_B    = 144;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_SRC-1:0] mon_clk = '0;
    logic              ref_clk_a = 1'b0;
    logic              ref_clk_b = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    fm_meter #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fm_meter (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_clk(mon_clk),
        .ref_clk_a(ref_clk_a), .ref_clk_b(ref_clk_b)
    );

    always #2.5 clk = ~clk;

    // Half periods in register clock cycles; sources 6 and 7 are stopped
    function automatic int half_per(input int i);
        case (i)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            default: return 8;
        endcase
    endfunction

    int mcnt [6];
    int rcnt_a = 0;
    int rcnt_b = 0;
    initial begin
        for (int i = 0; i < 6; i++) mcnt[i] = 0;
        mon_clk[7] = 1'b1;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (mcnt[i] == half_per(i) - 1) begin
                mcnt[i] <= 0;
                mon_clk[i] <= ~mon_clk[i];
            end else begin
                mcnt[i] <= mcnt[i] + 1;
            end
        end
        if (rcnt_a == PR_A/2 - 1) begin rcnt_a <= 0; ref_clk_a <= ~ref_clk_a; end
        else rcnt_a <= rcnt_a + 1;
        if (rcnt_b == PR_B/2 - 1) begin rcnt_b <= 0; ref_clk_b <= ~ref_clk_b; end
        else rcnt_b <= rcnt_b + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg(input int src, input int dv, input int rs,
                                        input int w, input bit en, input bit sr);
        return (32'(dv) << 28) | (32'(rs) << 24) | (32'(src) << 16) |
               (32'(en) << 15) | (32'(sr) << 14) | 32'(w);
    endfunction

    function automatic int expect_count(input int src, input int dv, input int rs, input int w);
        int pr, edges, c;
        if (src >= 6) return 0;
        pr = rs ? PR_B : PR_A;
        edges = ((w + 1) * pr) / (2 * half_per(src));
        c = edges >> dv;
        return (c > CMAX) ? CMAX : c;
    endfunction

    task automatic measure(input int src, input int dv, input int rs, input int w);
        logic [31:0] d, d2;
        int cyc, pr, exp;
        bit seen;
        string tag;
        pr  = rs ? PR_B : PR_A;
        exp = expect_count(src, dv, rs, w);
        if (src >= NUM_SRC)  tag = "R4 out-of-range source";
        else if (src >= 6)   tag = "R8 stopped source";
        else if (exp == CMAX) tag = "R10 saturation";
        else                 tag = "R4 R5 R3 count";
        bus_write(8'h10, cfg(0, 0, 0, 0, 0, 1));
        bus_write(8'h10, 32'h0);
        bus_write(8'h10, cfg(src, dv, rs, w, 1, 0));
        cyc = 0; seen = 0;
        while (!seen && cyc < (w + 3) * pr + 50) begin
            bus_read(8'h14, d);
            cyc++;
            if (d[31]) seen = 1;
        end
        check("R7 done bit set", 32'(seen), 1);
        check("R9 done not early", 32'(cyc >= (w + 1) * pr), 1);
        check("R9 done not late", 32'(cyc <= (w + 2) * pr + 8), 1);
        check(tag, longint'(d[CNT_W-1:0]), exp);
        repeat (40) @(negedge clk);
        bus_read(8'h14, d2);
        check("R7 result held", longint'(d2), longint'(d));
        bus_write(8'h10, cfg(0, 0, 0, 0, 0, 1));
        bus_write(8'h10, 32'h0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        bus_read(8'h10, d); check("R2 control reset", d, 0);
        bus_read(8'h14, d); check("R2 result reset", d, 0);
        bus_read(8'h00, d); check("R1 unmapped read", d, 0);

        // Readback with both enable and soft reset set: soft reset wins
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, d); check("R1 control readback", d, 32'h317F_CFFF);
        repeat (600) @(negedge clk);
        bus_read(8'h14, d); check("R6 enable ignored under soft reset", d, 0);
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, d); check("R1 control cleared", d, 0);

        // Soft reset in the middle of a run
        bus_write(8'h10, cfg(0, 0, 1, 3, 1, 0));
        repeat (300) @(negedge clk);
        bus_write(8'h10, cfg(0, 0, 1, 3, 1, 1));
        @(negedge clk);
        bus_read(8'h14, d); check("R6 mid-run clear", d, 0);
        repeat (700) @(negedge clk);
        bus_read(8'h14, d); check("R6 held cleared", d, 0);
        bus_write(8'h10, 32'h0);

        for (int s = 0; s < NUM_SRC; s++)
            for (int dv = 0; dv < 4; dv++)
                for (int rs = 0; rs < 2; rs++) begin
                    measure(s, dv, rs, 0);
                    measure(s, dv, rs, 2);
                end

        measure(9, 0, 0, 0);
        measure(127, 0, 1, 0);
        measure(5, 3, 0, 511);

        finished = 1;
        summary();
    end
endmodule